// File: doc/BRIEF.md
# Narrow-Port Access Splitter with Lane Steering

This block sits between an internal requester and the timing engine of an external memory port. It takes one internal access (byte, halfword, word or a four-word line) and turns it into a series of beats that fit the configured external port width. Each beat carries its own address, the data placed on the correct lanes of a 32-bit external data bus, and byte strobes for those lanes. A burst flag on every beat tells the timing engine whether the beats run as one chained burst or as separate cycles. Read beats are gathered back into the internal access layout and returned once.

The external port is either 32 bits or 8 bits wide. On an 8-bit port a shift setting picks the top or the bottom byte lane. Independent read and write burst enables decide how multi-beat accesses are marked, and a strobe mode decides whether byte strobes are also driven on read beats. All settings must be held steady while a request is in flight. Requests are assumed naturally aligned to their size.

Top module: `nps_splitter`

## Requirements
- R1: `req_ready` is high only while no request is in flight. The first beat of an accepted request is presented in the cycle after acceptance. A read is in flight until the cycle in which its response is presented.
- R2: An access of N bytes (byte 1, halfword 2, word 4, line 16) makes N beats on an 8-bit port. On a 32-bit port it makes 4 beats for a line and 1 beat otherwise. No extra beat follows the last one.
- R3: `cfg_port_size` 0 selects a 32-bit port and 1 selects an 8-bit port. The reserved codes 2 and 3 behave as a 32-bit port.
- R4: The first beat address equals `req_addr`. Each later beat address is one port width (1 or 4 bytes) above the one before.
- R5: An N-byte access uses bits [8N-1:0] of `req_wdata` and `rsp_rdata`, with the lowest-addressed byte in bits [8N-1:8N-8]. Beats are issued in address order, so the first beat carries that byte.
- R6: On an 8-bit port with `cfg_lane_shift`=0, data uses bits [31:24] with strobe pattern 4'b1000. With `cfg_lane_shift`=1 it uses bits [7:0] with 4'b0001.
- R7: On a 32-bit port, a byte at address offset k uses bits [31-8k:24-8k] and strobe bit 3-k. A halfword at offset 0 uses [31:16] and 4'b1100, at offset 2 it uses [15:0] and 4'b0011. A word or line beat uses all lanes and 4'b1111.
- R8: On a multi-beat access, `beat_burst` is 1 on every beat when the matching enable (`cfg_burst_wr` for writes, `cfg_burst_rd` for reads) is set, and 0 otherwise. A single-beat access has `beat_burst`=0.
- R9: `beat_last` is 1 on the final beat of a request and 0 on every other beat.
- R10: On write beats `beat_be` carries the lane pattern of R6/R7. On read beats it is 4'b0000 when `cfg_be_rdwr`=0 and the same lane pattern when `cfg_be_rdwr`=1.
- R11: `bus_rdata` is sampled in the cycle a read beat is accepted, using the lanes of R6/R7. `rsp_valid` is high for exactly one cycle, in the cycle after the final read beat is accepted, with the assembled data on `rsp_rdata`. Writes produce no `rsp_valid`.
- R12: While `beat_valid` is high and `beat_ready` is low, every beat output holds its value.
- R13: Lanes not used by a write beat, and all of `beat_data` on read beats, are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_port_size | input | 2 | External port width code |
| cfg_burst_rd | input | 1 | Mark multi-beat reads as bursts |
| cfg_burst_wr | input | 1 | Mark multi-beat writes as bursts |
| cfg_lane_shift | input | 1 | 8-bit port uses bottom lane when set |
| cfg_be_rdwr | input | 1 | Drive byte strobes on read beats too |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_addr | input | ADDR_W | Byte address of the access |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 line |
| req_wdata | input | 32*LINE_WORDS | Write data, layout per R5 |
| rsp_valid | output | 1 | Assembled read data valid |
| rsp_rdata | output | 32*LINE_WORDS | Assembled read data, layout per R5 |
| beat_valid | output | 1 | Beat presented |
| beat_ready | input | 1 | Timing engine accepts the beat |
| beat_addr | output | ADDR_W | Beat byte address |
| beat_write | output | 1 | Beat direction |
| beat_burst | output | 1 | Beat belongs to a chained burst |
| beat_last | output | 1 | Final beat of the request |
| beat_data | output | 32 | Lane-steered write data |
| beat_be | output | 4 | Byte strobes, bit 3 for bits [31:24] |
| bus_rdata | input | 32 | Read data of the accepted read beat |

## Verification
The bench targets the byte offsets within a word on the 32-bit port. A design that steers by the wrong offset bits would put a byte or halfword on the wrong lane or strobe. It drives filler on the unused lanes of the 8-bit port in both shift settings, so picking the wrong lane would return filler in the assembled word. It runs line accesses on both widths with bursts on and off and with stalls in the middle, where a wrong beat count, address step, burst flag or last marker, or an output that moves during a stall, shows up in the beat stream. It also checks the reserved width codes, the read strobe mode, and that a write never raises a response.

// File: rtl/nps_pkg.sv
package nps_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_LINE = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1,
    ST_RESP = 2'd2
  } seq_state_e;

  localparam logic [1:0] PORT_CODE_W8 = 2'd1;

  // bytes moved per beat
  function automatic logic [2:0] chunk_bytes(input logic port8, input acc_size_e sz);
    if (port8) return 3'd1;
    case (sz)
      SZ_BYTE: return 3'd1;
      SZ_HALF: return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // total bytes of an access
  function automatic int unsigned size_bytes(input acc_size_e sz, input int unsigned line_bytes);
    case (sz)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      SZ_WORD: return 4;
      default: return line_bytes;
    endcase
  endfunction

endpackage

// File: rtl/nps_beat_seq.sv
module nps_beat_seq
  import nps_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_port_size,
  input  logic              cfg_burst_rd,
  input  logic              cfg_burst_wr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_write,
  output logic              beat_burst,
  output logic              beat_last,
  output acc_size_e         cur_size,
  output logic              cur_port8,
  output logic              rsp_valid,
  output logic              start,
  output logic              adv
);

  localparam int LINE_BYTES = LINE_WORDS * 4;
  localparam int CNT_W      = $clog2(LINE_BYTES + 1);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              write_q, port8_q, burst_q;
  acc_size_e         size_q;
  logic              ctx_en, addr_en;
  logic              port8_n, burst_n;
  acc_size_e         size_n;
  logic [CNT_W-1:0]  beats_n;
  logic [2:0]        step;

  assign size_n  = acc_size_e'(req_size);
  assign port8_n = (cfg_port_size == PORT_CODE_W8);
  assign beats_n = port8_n ? CNT_W'(size_bytes(size_n, LINE_BYTES))
                           : ((size_n == SZ_LINE) ? CNT_W'(LINE_WORDS) : CNT_W'(1));
  assign burst_n = (beats_n > CNT_W'(1)) && (req_write ? cfg_burst_wr : cfg_burst_rd);

  assign start   = req_valid && (state_q == ST_IDLE);
  assign adv     = (state_q == ST_BEAT) && beat_ready;
  assign step    = chunk_bytes(port8_q, size_q);
  assign ctx_en  = start;
  assign addr_en = start || adv;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_BEAT;
        addr_d  = req_addr;
        rem_d   = beats_n;
      end
      ST_BEAT: if (adv) begin
        if (rem_q == CNT_W'(1)) begin
          state_d = write_q ? ST_IDLE : ST_RESP;
        end else begin
          addr_d = addr_q + ADDR_W'(step);
          rem_d  = rem_q - CNT_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      write_q <= 1'b0;
      port8_q <= 1'b0;
      burst_q <= 1'b0;
      size_q  <= SZ_BYTE;
    end else begin
      state_q <= state_d;
      if (addr_en) begin
        addr_q <= addr_d;
        rem_q  <= rem_d;
      end
      if (ctx_en) begin
        write_q <= req_write;
        port8_q <= port8_n;
        burst_q <= burst_n;
        size_q  <= size_n;
      end
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign beat_valid = (state_q == ST_BEAT);
  assign rsp_valid  = (state_q == ST_RESP);
  assign beat_addr  = addr_q;
  assign beat_write = write_q;
  assign beat_burst = burst_q;
  assign beat_last  = (rem_q == CNT_W'(1));
  assign cur_size   = size_q;
  assign cur_port8  = port8_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !beat_last |=> beat_valid && (beat_addr == $past(beat_addr) + ADDR_W'($past(step)))); // R4
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) && $stable(beat_last) && $stable(beat_burst)); // R12
  AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    adv && beat_last && !beat_write |=> rsp_valid); // R11
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid && req_ready); // R11
  AST_ACCEPT_THEN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> beat_valid && !req_ready); // R1

endmodule

// File: rtl/nps_lane_steer.sv
module nps_lane_steer
  import nps_pkg::*;
(
  input  logic        port8,
  input  logic        lane_shift,
  input  logic        be_rdwr,
  input  logic        write,
  input  acc_size_e   size,
  input  logic [1:0]  offs,
  input  logic [31:0] wr_top,
  input  logic [31:0] bus_rdata,
  output logic [31:0] beat_data,
  output logic [3:0]  beat_be,
  output logic [31:0] rd_chunk
);

  logic [31:0] data_w;
  logic [3:0]  mask;
  logic [1:0]  roff;
  logic [31:0] rsh;

  assign roff = 2'd3 - offs;
  assign rsh  = bus_rdata >> {roff, 3'b000};

  always_comb begin
    data_w   = wr_top;
    mask     = 4'b1111;
    rd_chunk = bus_rdata;
    if (port8) begin
      mask     = lane_shift ? 4'b0001 : 4'b1000;
      data_w   = lane_shift ? {24'h0, wr_top[31:24]} : {wr_top[31:24], 24'h0};
      rd_chunk = {24'h0, lane_shift ? bus_rdata[7:0] : bus_rdata[31:24]};
    end else begin
      case (size)
        SZ_BYTE: begin
          mask     = 4'b1000 >> offs;
          data_w   = {wr_top[31:24], 24'h0} >> {offs, 3'b000};
          rd_chunk = {24'h0, rsh[7:0]};
        end
        SZ_HALF: begin
          mask     = offs[1] ? 4'b0011 : 4'b1100;
          data_w   = offs[1] ? {16'h0, wr_top[31:16]} : {wr_top[31:16], 16'h0};
          rd_chunk = {16'h0, offs[1] ? bus_rdata[15:0] : bus_rdata[31:16]};
        end
        default: ;
      endcase
    end
  end

  assign beat_data = write ? data_w : 32'h0;
  assign beat_be   = (write || be_rdwr) ? mask : 4'b0000;

endmodule

// File: rtl/nps_data_shift.sv
module nps_data_shift
  import nps_pkg::*;
#(
  parameter int LINE_WORDS = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic                      adv,
  input  logic                      cur_write,
  input  logic [2:0]                chunk,
  input  logic [1:0]                req_size,
  input  logic [LINE_WORDS*32-1:0]  req_wdata,
  input  logic [31:0]               rd_chunk,
  output logic [31:0]               wr_top,
  output logic [LINE_WORDS*32-1:0]  acc
);

  localparam int LINE_BYTES = LINE_WORDS * 4;
  localparam int LINE_BITS  = LINE_BYTES * 8;
  localparam int SH_W       = $clog2(LINE_BITS);

  logic [LINE_BITS-1:0] wbuf_q, wbuf_d, acc_q, acc_d;
  logic [SH_W-1:0]      lsh;
  logic                 wbuf_en, acc_en;

  assign lsh     = SH_W'(8 * (LINE_BYTES - int'(size_bytes(acc_size_e'(req_size), LINE_BYTES))));
  assign wbuf_en = start || adv;
  assign acc_en  = start || (adv && !cur_write);

  always_comb begin
    wbuf_d = start ? (req_wdata << lsh) : (wbuf_q << {chunk, 3'b000});
    acc_d  = start ? '0
                   : ((acc_q << {chunk, 3'b000}) | {{(LINE_BITS-32){1'b0}}, rd_chunk});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbuf_q <= '0;
      acc_q  <= '0;
    end else begin
      if (wbuf_en) wbuf_q <= wbuf_d;
      if (acc_en)  acc_q  <= acc_d;
    end
  end

  assign wr_top = wbuf_q[LINE_BITS-1 -: 32];
  assign acc    = acc_q;

endmodule

// File: rtl/nps_splitter.sv
module nps_splitter
  import nps_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cfg_port_size,
  input  logic                     cfg_burst_rd,
  input  logic                     cfg_burst_wr,
  input  logic                     cfg_lane_shift,
  input  logic                     cfg_be_rdwr,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_write,
  input  logic [1:0]               req_size,
  input  logic [LINE_WORDS*32-1:0] req_wdata,
  output logic                     rsp_valid,
  output logic [LINE_WORDS*32-1:0] rsp_rdata,
  output logic                     beat_valid,
  input  logic                     beat_ready,
  output logic [ADDR_W-1:0]        beat_addr,
  output logic                     beat_write,
  output logic                     beat_burst,
  output logic                     beat_last,
  output logic [31:0]              beat_data,
  output logic [3:0]               beat_be,
  input  logic [31:0]              bus_rdata
);

  acc_size_e   cur_size;
  logic        cur_port8, start, adv;
  logic [2:0]  chunk;
  logic [31:0] wr_top, rd_chunk;

  nps_beat_seq #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) seq_i (
    .clk, .rst_n, .cfg_port_size, .cfg_burst_rd, .cfg_burst_wr,
    .req_valid, .req_ready, .req_addr, .req_write, .req_size,
    .beat_valid, .beat_ready, .beat_addr, .beat_write, .beat_burst, .beat_last,
    .cur_size, .cur_port8, .rsp_valid, .start, .adv
  );

  assign chunk = chunk_bytes(cur_port8, cur_size);

  nps_lane_steer steer_i (
    .port8(cur_port8), .lane_shift(cfg_lane_shift), .be_rdwr(cfg_be_rdwr),
    .write(beat_write), .size(cur_size), .offs(beat_addr[1:0]),
    .wr_top, .bus_rdata, .beat_data, .beat_be, .rd_chunk
  );

  nps_data_shift #(.LINE_WORDS(LINE_WORDS)) shift_i (
    .clk, .rst_n, .start, .adv, .cur_write(beat_write), .chunk,
    .req_size, .req_wdata, .rd_chunk, .wr_top, .acc(rsp_rdata)
  );

  AST_RD_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_write && !cfg_be_rdwr |-> beat_be == 4'b0000); // R10
  AST_NARROW_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && (cfg_port_size == PORT_CODE_W8) |-> $countones(beat_be) <= 1); // R6
  AST_SINGLE_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_size != 2'd3) && (cfg_port_size != PORT_CODE_W8) |=> !beat_burst); // R8

endmodule

// File: tb/nps_splitter_tb_top.sv
`timescale 1ns/1ps
module nps_splitter_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   cfg_port_size;
  logic         cfg_burst_rd, cfg_burst_wr, cfg_lane_shift, cfg_be_rdwr;
  logic         req_valid, req_ready, req_write;
  logic [31:0]  req_addr;
  logic [1:0]   req_size;
  logic [127:0] req_wdata, rsp_rdata;
  logic         rsp_valid, beat_valid, beat_ready, beat_write, beat_burst, beat_last;
  logic [31:0]  beat_addr, beat_data, bus_rdata;
  logic [3:0]   beat_be;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  nps_splitter dut_i (
    .clk, .rst_n, .cfg_port_size, .cfg_burst_rd, .cfg_burst_wr, .cfg_lane_shift, .cfg_be_rdwr,
    .req_valid, .req_ready, .req_addr, .req_write, .req_size, .req_wdata,
    .rsp_valid, .rsp_rdata, .beat_valid, .beat_ready, .beat_addr, .beat_write,
    .beat_burst, .beat_last, .beat_data, .beat_be, .bus_rdata
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [31:0] x);
    return x[7:0] * 8'd7 + 8'd3;
  endfunction

  task automatic do_access(input logic [31:0] a, input logic wr, input logic [1:0] sz,
                           input logic [127:0] wd, input int stall_mod);
    int n, beats, chunk, idx, lane;
    logic port8;
    logic [31:0] baddr, x, ed, rb;
    logic [3:0] eb;
    logic [127:0] er;
    port8 = (cfg_port_size == 2'd1);
    n     = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 16;
    beats = port8 ? n : ((sz == 3) ? 4 : 1);
    chunk = port8 ? 1 : ((n > 4) ? 4 : n);
    @(negedge clk);
    chk("R1 ready before request", {127'h0, req_ready}, 128'h1);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_wdata = '1;
    for (int j = 0; j < beats; j++) begin
      baddr = a + 32'(j * chunk);
      ed = '0; eb = '0;
      for (int k = 0; k < chunk; k++) begin
        idx  = j * chunk + k;
        x    = baddr + 32'(k);
        lane = port8 ? (cfg_lane_shift ? 0 : 3) : 3 - int'(x[1:0]);
        ed[8*lane +: 8] = wd[8*(n-1-idx) +: 8];
        eb[lane] = 1'b1;
      end
      if (!wr) ed = '0;
      if (!wr && !cfg_be_rdwr) eb = '0;
      if (port8) rb = cfg_lane_shift ? {24'hA5A5A5, mem_byte(baddr)} : {mem_byte(baddr), 24'hA5A5A5};
      else rb = {mem_byte({baddr[31:2], 2'b00}), mem_byte({baddr[31:2], 2'b01}),
                 mem_byte({baddr[31:2], 2'b10}), mem_byte({baddr[31:2], 2'b11})};
      for (int s = 0; s < 2; s++) begin
        if (s == 1 && !(stall_mod != 0 && (j % stall_mod) == 0)) break;
        chk("R2 beat present", {127'h0, beat_valid}, 128'h1);
        chk("R1 busy during beats", {127'h0, req_ready}, 128'h0);
        chk(s ? "R12 R4 stalled address" : "R4 beat address", {96'h0, beat_addr}, {96'h0, baddr});
        chk(port8 ? "R6 R5 R13 lane data" : "R7 R5 R13 lane data", {96'h0, beat_data}, {96'h0, ed});
        chk(wr ? "R6 R7 write strobes" : "R10 read strobes", {124'h0, beat_be}, {124'h0, eb});
        chk("R8 burst flag", {127'h0, beat_burst}, {127'h0, (beats > 1) && (wr ? cfg_burst_wr : cfg_burst_rd)});
        chk("R9 last flag", {127'h0, beat_last}, {127'h0, j == beats - 1});
        if (s == 0 && stall_mod != 0 && (j % stall_mod) == 0) begin
          beat_ready = 1'b0;
          @(negedge clk);
        end
      end
      beat_ready = 1'b1; bus_rdata = rb;
      @(negedge clk);
      beat_ready = 1'b0; bus_rdata = 32'h5A5A5A5A;
    end
    if (!wr) begin
      er = '0;
      for (int i = 0; i < n; i++) er[8*(n-1-i) +: 8] = mem_byte(a + 32'(i));
      chk("R11 response valid", {127'h0, rsp_valid}, 128'h1);
      chk("R11 R5 assembled read data", rsp_rdata, er);
      chk("R2 no extra beat", {127'h0, beat_valid}, 128'h0);
      chk("R1 busy while responding", {127'h0, req_ready}, 128'h0);
      @(negedge clk);
      chk("R11 response one cycle", {127'h0, rsp_valid}, 128'h0);
      chk("R1 ready after response", {127'h0, req_ready}, 128'h1);
    end else begin
      chk("R11 no response on write", {127'h0, rsp_valid}, 128'h0);
      chk("R2 no extra beat", {127'h0, beat_valid}, 128'h0);
      chk("R1 ready after write", {127'h0, req_ready}, 128'h1);
    end
  endtask

  task automatic set_cfg(input logic [1:0] ps, input logic br, input logic bw,
                         input logic sh, input logic bm);
    cfg_port_size = ps; cfg_burst_rd = br; cfg_burst_wr = bw; cfg_lane_shift = sh; cfg_be_rdwr = bm;
  endtask

  task automatic t_reset;
    chk("R1 reset ready", {127'h0, req_ready}, 128'h1);
    chk("R1 reset no beat", {127'h0, beat_valid}, 128'h0);
    chk("R11 reset no response", {127'h0, rsp_valid}, 128'h0);
  endtask

  task automatic t_port32_single;
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < 4; k++) do_access(32'h10 + 32'(k), 1'b1, 2'd0, 128'hC0 + 128'(k), 0); // R7 byte lanes
    do_access(32'h20, 1'b1, 2'd1, 128'hBEEF, 0);
    do_access(32'h22, 1'b1, 2'd1, 128'hCAFE, 1);
    do_access(32'h30, 1'b1, 2'd2, 128'h11223344, 0);
    do_access(32'h41, 1'b0, 2'd0, '0, 0);
    do_access(32'h43, 1'b0, 2'd0, '0, 0);
    do_access(32'h42, 1'b0, 2'd1, '0, 0);
    do_access(32'h44, 1'b0, 2'd2, '0, 1);
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b1); // R10 strobes on reads
    do_access(32'h45, 1'b0, 2'd0, '0, 0);
    do_access(32'h40, 1'b0, 2'd1, '0, 0);
  endtask

  task automatic t_port8;
    set_cfg(2'd1, 1'b1, 1'b0, 1'b0, 1'b0); // R6 top lane
    do_access(32'h50, 1'b1, 2'd2, 128'h11223344, 2);
    do_access(32'h54, 1'b0, 2'd2, '0, 0);
    set_cfg(2'd1, 1'b0, 1'b1, 1'b1, 1'b0); // R6 bottom lane
    do_access(32'h60, 1'b1, 2'd1, 128'hA1B2, 0);
    do_access(32'h61, 1'b0, 2'd0, '0, 0);
    do_access(32'h64, 1'b0, 2'd2, '0, 3);
    set_cfg(2'd1, 1'b1, 1'b1, 1'b1, 1'b1);
    do_access(32'h6A, 1'b0, 2'd1, '0, 0);
  endtask

  task automatic t_lines;
    set_cfg(2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    do_access(32'h80, 1'b0, 2'd3, '0, 2);
    do_access(32'h90, 1'b1, 2'd3, 128'h00112233_44556677_8899AABB_CCDDEEFF, 0);
    set_cfg(2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    do_access(32'hA0, 1'b1, 2'd3, 128'hF0E1D2C3_B4A59687_78695A4B_3C2D1E0F, 3);
    set_cfg(2'd1, 1'b0, 1'b1, 1'b1, 1'b1);
    do_access(32'hB0, 1'b0, 2'd3, '0, 5);
  endtask

  task automatic t_reserved;
    set_cfg(2'd2, 1'b0, 1'b0, 1'b1, 1'b0); // R3 code 2 acts as 32-bit
    do_access(32'h08, 1'b1, 2'd2, 128'hDEADBEEF, 0);
    set_cfg(2'd3, 1'b1, 1'b0, 1'b1, 1'b0); // R3 code 3 acts as 32-bit
    do_access(32'h0D, 1'b0, 2'd0, '0, 0);
    do_access(32'h00, 1'b0, 2'd3, '0, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_write = 1'b0; req_size = '0;
    req_wdata = '0; beat_ready = 1'b0; bus_rdata = '0;
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_port32_single;
    t_port8;
    t_lines;
    t_reserved;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

endmodule